// File: doc/BRIEF.md
# GPIO alternate-function write guard

This block guards the pin-function selection of an 8-bit general purpose I/O port against stray software writes. It holds three pieces of state: a lock flag, a commit mask and the alternate-function select register that picks, pin by pin, whether a pad is driven by the port or by another peripheral.

Software opens the guard by writing a fixed 32-bit key to the lock register. While the guard is open, software may load a new commit mask. The commit mask then decides, bit by bit, which alternate-function select bits a later write may change. Bits outside the mask keep their value. Writing any value other than the key closes the guard again. The stored mask is not touched when the guard closes.

All registers sit on a simple word-addressed bus that completes every access in one cycle. The select register and the commit mask are exported as ports for the pad logic around the block.

Top module: `gpio_guard`

## Requirements
- R1: A write of exactly 0x0ACCE551 to the lock register (word address 0x148) clears the lock flag.
- R2: A write of any other value to the lock register sets the lock flag. A value that differs from the key only in bits 31:28 also sets it.
- R3: A read of the lock register returns 1 in bit 0 while locked and 0 while unlocked. All other bits read 0.
- R4: While unlocked, a write to the commit register (word address 0x149) stores the low 8 bits of the write data. The register reads back zero-extended.
- R5: While locked, a write to the commit register leaves the commit mask unchanged.
- R6: A write to the alternate-function select register (word address 0x108) changes only the bits whose commit-mask bit is 1. The other bits keep their value, whether the unit is locked or not.
- R7: After reset the lock flag is 1, the commit mask is 0xFF and the alternate-function select is 0x00.
- R8: Setting the lock flag again leaves the stored commit mask unchanged.
- R9: Read data is registered. The value present after a clock edge shows the addressed register as it was before that edge, including any write in the same cycle. An unmapped address reads 0.
- R10: The `func_sel` and `commit_mask` ports show the new register values right after the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 10 | Word address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the address of the previous cycle |
| func_sel | output | 8 | Alternate-function select, one bit per pin |
| commit_mask | output | 8 | Commit mask, one bit per pin |

## Verification
A write to the lock, commit or select register takes effect at the clock edge that samples the strobe. The exported ports therefore change at that same edge, and the bench samples them at the following falling edge. Read data goes through one register: a read is issued for one full cycle and sampled at the falling edge after the capturing rising edge. The bench also samples the read data in the cycle of a lock write, to confirm that the pre-write value is returned. Every stimulus is applied on a falling edge, so each result is checked half a cycle after the edge that must produce it.

// File: rtl/gg_pkg.sv
package gg_pkg;

  // Byte offsets inside the peripheral window; the bus carries word addresses.
  localparam int unsigned ALT_BYTE_OFS    = 32'h420;
  localparam int unsigned LOCK_BYTE_OFS   = 32'h520;
  localparam int unsigned COMMIT_BYTE_OFS = 32'h524;

  // Key that opens the guard.
  localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ALT    = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_COMMIT = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gg_rst_sync.sv
module gg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[DEPTH-1];

endmodule

// File: rtl/gg_decode.sv
module gg_decode
  import gg_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              we_alt,
  output logic              we_lock,
  output logic              we_commit
);

  localparam logic [ADDR_W-1:0] A_ALT    = ADDR_W'(ALT_BYTE_OFS    >> 2);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(LOCK_BYTE_OFS   >> 2);
  localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(COMMIT_BYTE_OFS >> 2);

  always_comb begin
    if (addr == A_ALT) begin
      sel = SEL_ALT;
    end else if (addr == A_LOCK) begin
      sel = SEL_LOCK;
    end else if (addr == A_COMMIT) begin
      sel = SEL_COMMIT;
    end else begin
      sel = SEL_NONE;
    end
  end

  always_comb begin
    we_alt    = wr_en && (sel == SEL_ALT);
    we_lock   = wr_en && (sel == SEL_LOCK);
    we_commit = wr_en && (sel == SEL_COMMIT);
  end

endmodule

// File: rtl/gg_lock_commit.sv
module gg_lock_commit
  import gg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIN_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lock,
  input  logic              we_commit,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic [PIN_N-1:0]  commit
);

  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

  logic             lock_q;
  logic             lock_d;
  logic             lock_en;
  logic [PIN_N-1:0] commit_q;
  logic [PIN_N-1:0] commit_d;
  logic             commit_en;
  logic             key_match;

  always_comb begin
    key_match = (wdata == KEY_W);
    lock_en   = we_lock;
    lock_d    = !key_match;
    commit_en = we_commit && !lock_q;
    commit_d  = wdata[PIN_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= '1;
    end else if (commit_en) begin
      commit_q <= commit_d;
    end
  end

  assign locked = lock_q;
  assign commit = commit_q;

  // R1
  key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lock && wdata == KEY_W) |=> !locked);

  // R2
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lock && wdata != KEY_W) |=> locked);

  // R5
  commit_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_commit && locked) |=> $stable(commit));

  // R4
  commit_open_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_commit && !locked) |=> (commit == $past(wdata[PIN_N-1:0])));

  // R8
  commit_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_commit |=> $stable(commit));

endmodule

// File: rtl/gg_altsel.sv
module gg_altsel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIN_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_alt,
  input  logic [PIN_N-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [PIN_N-1:0]  func_sel
);

  logic [PIN_N-1:0] sel_q;
  logic [PIN_N-1:0] sel_d;
  logic [PIN_N-1:0] bit_en;

  always_comb begin
    sel_d  = wdata[PIN_N-1:0];
    bit_en = {PIN_N{we_alt}} & mask;
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= 1'b0;
      end else if (bit_en[i]) begin
        sel_q[i] <= sel_d[i];
      end
    end
  end

  assign func_sel = sel_q;

  // R6
  alt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_alt |=> (((func_sel ^ $past(func_sel)) & ~$past(mask)) == '0));

  // R6
  alt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_alt |=> ((func_sel & $past(mask)) == ($past(wdata[PIN_N-1:0]) & $past(mask))));

  // R6
  alt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_alt |=> $stable(func_sel));

endmodule

// File: rtl/gpio_guard.sv
module gpio_guard
  import gg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PIN_N     = 8,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PIN_N-1:0]  func_sel,
  output logic [PIN_N-1:0]  commit_mask
);

  logic              srst_n;
  reg_sel_e          sel;
  logic              we_alt;
  logic              we_lock;
  logic              we_commit;
  logic              locked;
  logic [PIN_N-1:0]  commit;
  logic [PIN_N-1:0]  alt;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  gg_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en     (wr_en),
    .addr      (addr),
    .sel       (sel),
    .we_alt    (we_alt),
    .we_lock   (we_lock),
    .we_commit (we_commit)
  );

  gg_lock_commit #(.DATA_W(DATA_W), .PIN_N(PIN_N)) u_lock (
    .clk       (clk),
    .rst_n     (srst_n),
    .we_lock   (we_lock),
    .we_commit (we_commit),
    .wdata     (wdata),
    .locked    (locked),
    .commit    (commit)
  );

  gg_altsel #(.DATA_W(DATA_W), .PIN_N(PIN_N)) u_alt (
    .clk      (clk),
    .rst_n    (srst_n),
    .we_alt   (we_alt),
    .mask     (commit),
    .wdata    (wdata),
    .func_sel (alt)
  );

  always_comb begin
    unique case (sel)
      SEL_ALT:    rd_d = DATA_W'(alt);
      SEL_LOCK:   rd_d = DATA_W'(locked);
      SEL_COMMIT: rd_d = DATA_W'(commit);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata       = rd_q;
  assign func_sel    = alt;
  assign commit_mask = commit;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sel == SEL_NONE) |=> (rdata == '0));

  // R3
  lock_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sel == SEL_LOCK) |=> (rdata == DATA_W'($past(locked))));

endmodule

// File: tb/gpio_guard_tb.sv
module gpio_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] A_ALT    = 10'h108;
  localparam logic [9:0] A_LOCK   = 10'h148;
  localparam logic [9:0] A_COMMIT = 10'h149;
  localparam logic [9:0] A_NONE   = 10'h000;
  localparam logic [31:0] KEY     = 32'h0ACC_E551;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  func_sel;
  logic [7:0]  commit_mask;

  int errors = 0;
  int checks = 0;

  gpio_guard u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .func_sel    (func_sel),
    .commit_mask (commit_mask)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    do_read(A_LOCK, v);   check("R7 R3 lock after reset", v, 32'h1);
    do_read(A_COMMIT, v); check("R7 commit after reset", v, 32'hFF);
    do_read(A_ALT, v);    check("R7 afsel after reset", v, 32'h0);
    check("R7 func_sel port", {24'h0, func_sel}, 32'h0);
    check("R7 commit_mask port", {24'h0, commit_mask}, 32'hFF);
  endtask

  task automatic t_unlock;
    logic [31:0] v;
    do_read(A_LOCK, v);
    do_write(A_LOCK, KEY);
    check("R9 read in write cycle shows old lock", rdata, 32'h1);
    do_read(A_LOCK, v);   check("R1 R3 unlocked reads 0", v, 32'h0);
  endtask

  task automatic t_commit_load;
    logic [31:0] v;
    do_write(A_COMMIT, 32'h1234_5A3C);
    check("R10 R4 commit_mask port after write", {24'h0, commit_mask}, 32'h3C);
    do_read(A_COMMIT, v); check("R4 commit low byte stored", v, 32'h3C);
  endtask

  task automatic t_alt_masked;
    logic [31:0] v;
    do_write(A_ALT, 32'hFFFF_FFFF);
    check("R10 R6 func_sel port after write", {24'h0, func_sel}, 32'h3C);
    do_read(A_ALT, v);    check("R6 afsel masked by 0x3C", v, 32'h3C);
    do_write(A_COMMIT, 32'h0F);
    do_write(A_ALT, 32'hFF);
    do_read(A_ALT, v);    check("R6 afsel bits outside 0x0F kept", v, 32'h3F);
    do_write(A_COMMIT, 32'hF0);
    do_write(A_ALT, 32'h00);
    do_read(A_ALT, v);    check("R6 low bits preserved under mask 0xF0", v, 32'h0F);
  endtask

  task automatic t_relock;
    logic [31:0] v;
    do_write(A_LOCK, 32'h0ACC_E550);
    do_read(A_LOCK, v);   check("R2 R3 near-key relocks", v, 32'h1);
    do_read(A_COMMIT, v); check("R8 commit kept on relock", v, 32'hF0);
    do_write(A_COMMIT, 32'h00);
    do_read(A_COMMIT, v); check("R5 commit write while locked ignored", v, 32'hF0);
    check("R5 commit_mask port unchanged", {24'h0, commit_mask}, 32'hF0);
    do_write(A_ALT, 32'hA5);
    do_read(A_ALT, v);    check("R6 afsel masked while locked", v, 32'hAF);
    do_write(A_LOCK, KEY);
    do_read(A_LOCK, v);   check("R1 key unlocks again", v, 32'h0);
    do_write(A_LOCK, 32'h1ACC_E551);
    do_read(A_LOCK, v);   check("R2 key with wrong top bits locks", v, 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    do_read(A_NONE, v);   check("R9 unmapped reads zero", v, 32'h0);
    do_read(10'h3FF, v);  check("R9 high unmapped reads zero", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_unlock;
    t_commit_load;
    t_alt_masked;
    t_relock;
    t_unmapped;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule